// File: doc/BRIEF.md
# Read Output Pipeline with Deselect

This block forms the last stage of the read path in a synchronous burst static RAM. Read and deselect commands are accepted on rising clock edges. The data the array returns for a command is then steered onto the output bus through one of two timing paths. A static mode input picks the path:

- **Flow-through (mode low):** array data reaches the bus without passing through a register.
- **Pipelined (mode high):** array data is first captured in an output register on a rising edge, which costs one extra cycle.

Deselect commands travel down the same valid pipeline as reads. The output drivers therefore switch off after exactly as many clock edges as a read takes to switch them on. With the output register in use, this gives the dual-cycle-deselect behaviour.

Two asynchronous inputs gate the drivers directly:

- An active-low output enable.
- An active-high sleep input. While sleep is asserted, queued pipeline contents are also discarded.

The block presents a data bus together with a drive-enable that the pad ring uses to control the tristate buffers. The array, the address counter and test logic are not part of this block.

Top module: `odp_read_out`

## Requirements
- R1: While and after a synchronous active-high reset, `drive_o` is 0 and `dq_o` is all zeros, until a read command reaches the output.
- R2: With the sampled mode low (flow-through), a read accepted at clock edge k makes `drive_o` high in the cycle after edge k. In that cycle `dq_o` equals the live `arr_data_i` (first data two edges after the address edge of the array stage, i.e. 2-1-1-1).
- R3: With the sampled mode high (pipelined), `arr_data_i` is captured at the edge after the read's edge. `drive_o` and `dq_o` show it one cycle later than in flow-through (3-1-1-1).
- R4: Back-to-back read commands give one new data beat on `dq_o` per clock cycle in either mode.
- R5: A deselect command wins over a read in the same cycle. It turns `drive_o` off after the same number of edges that a read takes to turn it on: one edge in flow-through, two in pipelined.
- R6: A cycle with neither a read nor a deselect strobe keeps the command-stage valid state as it was.
- R7: `oe_n_i` high forces `drive_o` low at once, without a clock edge. It does not disturb the pipeline, so the output comes back when `oe_n_i` returns low.
- R8: `sleep_i` high forces `drive_o` low at once. Every rising edge seen while it is high empties both pipeline stages.
- R9: The mode input is sampled on every rising edge. The edge at which the sampled value changes empties both pipeline stages, and output selection follows only the sampled value.
- R10: Whenever `drive_o` is low, `dq_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_pipe_i | input | 1 | Static mode: 0 selects flow-through, 1 selects pipelined |
| rd_i | input | 1 | Read command strobe for this edge |
| desel_i | input | 1 | Deselect command strobe for this edge (overrides `rd_i`) |
| arr_data_i | input | DATA_W | Array read data for the command in the command stage |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| dq_o | output | DATA_W | Output data, zero when not driving |
| drive_o | output | 1 | Output driver enable, active high |

## Verification
Directed sequences are run in each mode:

- A single read followed by idle cycles tells the flow-through latency apart from the pipelined latency.
- A run of consecutive reads shows a beat every cycle.
- A deselect placed after reads shows that turn-off takes the same number of edges as turn-on.
- An idle cycle with no strobe tells "hold" apart from "clear".

Output-enable and sleep pulses in the middle of a stream separate pure driver gating from pipeline flushing. A mode flip with a read in flight shows the flush. Random strobes, enables, sleep pulses and rare mode flips are then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/odp_pkg.sv
package odp_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } odp_mode_e;

  typedef struct packed {
    logic vld;
  } odp_stage_t;
endpackage

// File: rtl/odp_mode_sync.sv
module odp_mode_sync
  import odp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_i,
  output odp_mode_e mode_q,
  output logic      chg_o
);
  always_ff @(posedge clk) begin
    mode_q <= odp_mode_e'(mode_i);
  end

  // A reset edge takes the mode without calling it a change.
  assign chg_o = !rst && (odp_mode_e'(mode_i) != mode_q);
endmodule

// File: rtl/odp_cmd_stage.sv
module odp_cmd_stage (
  input  logic clk,
  input  logic rst,
  input  logic flush_i,
  input  logic rd_i,
  input  logic desel_i,
  input  logic sleep_i,
  output logic vld_o
);
  always_ff @(posedge clk) begin
    if (rst || flush_i)  vld_o <= 1'b0;
    else if (desel_i)    vld_o <= 1'b0;
    else if (rd_i)       vld_o <= 1'b1;
  end

  a_r5_desel_clears: assert property (@(posedge clk) disable iff (rst)
    desel_i |=> !vld_o);
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !desel_i && !flush_i) |=> $stable(vld_o));
  a_r8_sleep_empties_cmd: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !vld_o);
endmodule

// File: rtl/odp_out_stage.sv
module odp_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              sleep_i,
  input  logic              in_vld_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_data_o
);
  always_ff @(posedge clk) begin
    if (rst || flush_i) out_vld_o <= 1'b0;
    else                out_vld_o <= in_vld_i;
  end

  // The data register loads only behind a valid beat, so it is idle otherwise.
  always_ff @(posedge clk) begin
    if (rst)                      out_data_o <= '0;
    else if (in_vld_i && !flush_i) out_data_o <= in_data_i;
  end

  a_r8_sleep_empties_out: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !out_vld_o);
  a_r3_beat_carried: assert property (@(posedge clk) disable iff (rst)
    (in_vld_i && !flush_i) |=> (out_vld_o && out_data_o == $past(in_data_i)));
endmodule

// File: rtl/odp_drive_gate.sv
module odp_drive_gate
  import odp_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  odp_mode_e         mode_i,
  input  logic              ft_vld_i,
  input  logic [DATA_W-1:0] ft_data_i,
  input  logic              pp_vld_i,
  input  logic [DATA_W-1:0] pp_data_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              drive_o
);
  logic              sel_vld;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    if (mode_i == MODE_PIPE) begin
      sel_vld  = pp_vld_i;
      sel_data = pp_data_i;
    end else begin
      sel_vld  = ft_vld_i;
      sel_data = ft_data_i;
    end
    drive_o = sel_vld && !oe_n_i && !sleep_i;
    dq_o    = drive_o ? sel_data : '0;
  end
endmodule

// File: rtl/odp_read_out.sv
module odp_read_out
  import odp_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pipe_i,
  input  logic              rd_i,
  input  logic              desel_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              drive_o
);
  odp_mode_e         mode_q;
  logic              mode_chg;
  logic              flush;
  logic              s1_vld;
  logic              s2_vld;
  logic [DATA_W-1:0] s2_data;

  assign flush = sleep_i || mode_chg;

  odp_mode_sync u_mode (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_pipe_i),
    .mode_q (mode_q),
    .chg_o  (mode_chg)
  );

  odp_cmd_stage u_cmd (
    .clk     (clk),
    .rst     (rst),
    .flush_i (flush),
    .rd_i    (rd_i),
    .desel_i (desel_i),
    .sleep_i (sleep_i),
    .vld_o   (s1_vld)
  );

  odp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (flush),
    .sleep_i    (sleep_i),
    .in_vld_i   (s1_vld),
    .in_data_i  (arr_data_i),
    .out_vld_o  (s2_vld),
    .out_data_o (s2_data)
  );

  odp_drive_gate #(.DATA_W(DATA_W)) u_gate (
    .mode_i    (mode_q),
    .ft_vld_i  (s1_vld),
    .ft_data_i (arr_data_i),
    .pp_vld_i  (s2_vld),
    .pp_data_i (s2_data),
    .oe_n_i    (oe_n_i),
    .sleep_i   (sleep_i),
    .dq_o      (dq_o),
    .drive_o   (drive_o)
  );

  a_r10_zero_when_off: assert property (@(posedge clk) disable iff (rst)
    !drive_o |-> (dq_o == '0));
  a_r7_oe_blocks: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> !drive_o);
  a_r9_mode_flip_flush: assert property (@(posedge clk) disable iff (rst)
    (mode_pipe_i != mode_q) |=> (!s1_vld && !s2_vld && !drive_o));
  a_r8_sleep_off: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> !drive_o);
endmodule

// File: tb/tb_odp_read_out.sv
module tb_odp_read_out;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         md = 1'b0, rd = 1'b0, ds = 1'b0, oe = 1'b0, sl = 1'b0;
  logic [W-1:0] ad = '0;
  logic [W-1:0] dq;
  logic         drv;

  int checks = 0;
  int fails  = 0;

  // Reference state built from the requirements.
  logic         m_mode = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;
  logic [W-1:0] m_d2 = '0;

  always #2 clk = ~clk;

  odp_read_out #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .mode_pipe_i(md), .rd_i(rd), .desel_i(ds),
    .arr_data_i(ad), .oe_n_i(oe), .sleep_i(sl), .dq_o(dq), .drive_o(drv)
  );

  function automatic logic exp_drive();
    return (m_mode ? m_s2 : m_s1) && !oe && !sl;
  endfunction

  function automatic logic [W-1:0] exp_dq();
    if (!exp_drive()) return '0;
    return m_mode ? m_d2 : ad;
  endfunction

  task automatic check(string tag);
    logic         ed = exp_drive();
    logic [W-1:0] eq = exp_dq();
    checks++;
    if (drv !== ed) begin
      fails++;
      $display("FAIL %s drive_o actual=%b expected=%b t=%0t", tag, drv, ed, $time);
    end
    checks++;
    if (dq !== eq) begin
      fails++;
      $display("FAIL %s dq_o actual=%h expected=%h t=%0t",
               ed ? tag : "R10", dq, eq, $time);
    end
  endtask

  task automatic model_edge();
    logic flush = sl || (md != m_mode);
    if (rst) begin
      m_s1 = 1'b0; m_s2 = 1'b0; m_d2 = '0;
    end else begin
      if (m_s1 && !flush) m_d2 = ad;
      m_s2 = flush ? 1'b0 : m_s1;
      if (flush || ds) m_s1 = 1'b0;
      else if (rd)     m_s1 = 1'b1;
    end
    m_mode = md;
  endtask

  task automatic tick(logic r, logic d, logic o, logic s, logic [W-1:0] a, string tag);
    rd = r; ds = d; oe = o; sl = s; ad = a;
    #1;
    check(tag);
    @(posedge clk);
    model_edge();
    #1;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    md = 1'b0;
    @(posedge clk); model_edge();
    @(posedge clk); model_edge();
    #1;
    tick(0, 0, 0, 0, 36'h0AA, "R1");
    rst = 1'b0;
    tick(0, 0, 0, 0, 36'h0BB, "R1");

    // Flow-through latency and live data.
    tick(1, 0, 0, 0, 36'h111, "R2");
    tick(0, 0, 0, 0, 36'h222, "R2");
    tick(1, 0, 0, 0, 36'h333, "R4");
    tick(1, 0, 0, 0, 36'h444, "R4");
    tick(1, 0, 0, 0, 36'h555, "R4");
    tick(1, 1, 0, 0, 36'h666, "R5");   // deselect wins over read
    tick(0, 0, 0, 0, 36'h777, "R5");
    tick(0, 0, 0, 0, 36'h888, "R6");   // stays off
    tick(1, 0, 0, 0, 36'h999, "R6");
    tick(0, 0, 0, 0, 36'hAAA, "R6");   // stays on
    tick(0, 0, 1, 0, 36'hBBB, "R7");   // oe high: off, no edge needed
    tick(0, 0, 0, 0, 36'hCCC, "R7");   // back on
    tick(0, 0, 0, 1, 36'hDDD, "R8");
    tick(0, 0, 0, 0, 36'hEEE, "R8");   // pipeline emptied

    // Mode flip with a read in flight.
    tick(1, 0, 0, 0, 36'h121, "R9");
    md = 1'b1;
    tick(0, 0, 0, 0, 36'h232, "R9");
    tick(0, 0, 0, 0, 36'h343, "R9");

    // Pipelined latency and deselect depth.
    tick(1, 0, 0, 0, 36'h454, "R3");
    tick(0, 0, 0, 0, 36'h565, "R3");
    tick(1, 0, 0, 0, 36'h676, "R3");
    tick(1, 0, 0, 0, 36'h787, "R4");
    tick(0, 1, 0, 0, 36'h898, "R5");
    tick(0, 0, 0, 0, 36'h9A9, "R5");
    tick(0, 0, 0, 0, 36'hABA, "R5");
    tick(1, 0, 0, 0, 36'hBCB, "R7");
    tick(0, 0, 1, 0, 36'hCDC, "R7");
    tick(0, 0, 0, 0, 36'hDED, "R7");
    tick(0, 0, 0, 1, 36'hEFE, "R8");
    tick(0, 0, 0, 0, 36'hF0F, "R8");

    for (int i = 0; i < 3000; i++) begin
      logic r = ($urandom % 3) != 0;
      logic d = ($urandom % 6) == 0;
      logic o = ($urandom % 8) == 0;
      logic s = ($urandom % 16) == 0;
      logic [W-1:0] a = {$urandom, $urandom};
      if (($urandom % 100) == 0) md = ~md;
      tick(r, d, o, s, a, m_mode ? "R3" : "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule